// File: doc/BRIEF.md
# Strobe-Handshake Host Register Port

This block is the slave side of an asynchronous parallel host bus. A microprocessor selects the port with an active-low chip enable and marks each transfer with an active-low strobe. A direction line picks read or write. Address and data come from a 5-bit address and a 16-bit data bus. The bidirectional data bus is modelled as separate input, output and output-enable signals. The acknowledge output has its own enable, so that it can sit in high impedance between transfers. The strobe, chip-enable and direction inputs are brought into the system clock domain through two-flop synchronizers. A transfer begins when the synchronized strobe falls while chip enable is low.

Behind the port is a small register file. Location 0 holds interrupt status bits, which are set by event pulses and cleared by writing ones. Location 1 holds the interrupt mask. Locations 2 to 31 are plain storage. The interrupt output is a level equal to the OR of the status bits that are not masked off. When a transfer begins, read data is copied into an output register and is held there until the host lifts the strobe. The acknowledge is driven low once the write or read data has been registered. It is released as soon as the strobe rises, and every bus output is gated by chip enable.

Top module: `strobe_reg_port`

## Requirements
- R1: After the active-low asynchronous reset, all locations read as zero, irq is 0, and d_oe and ack_oe are 0.
- R2: While ce_n is high, d_oe and ack_oe are 0 whatever the strobe does. A strobe pulse with ce_n high changes no location.
- R3: A write cycle (rd_wr = 0) to an address from 2 to 31 stores d_in, and a later read of that address returns it.
- R4: d_oe is 1 only while ce_n is low, stb_n is low and rd_wr is high, in a cycle that has been acknowledged. While d_oe is 1, d_out carries the addressed location.
- R5: The acknowledge (ack_oe = 1 with ack_n = 0) appears within four clocks after stb_n falls. It is never present in the clock in which the fall is first sampled, and it is released as soon as stb_n rises.
- R6: ce_n may stay low across back-to-back cycles, and each strobe low pulse is handled as a separate transfer.
- R7: A 1 on bit i of evt_set for one clock sets status bit i at address 0. irq equals the OR over all bits of (status AND mask), where the mask is the value at address 1.
- R8: A write to address 0 clears every status bit whose data bit is 1 and leaves the other status bits unchanged. An event on a bit in the same clock wins over the clear.
- R9: Read data is captured at the start of the cycle, and d_out stays stable while the strobe is held low, even if the addressed location changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| stb_n | input | 1 | Transfer strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address |
| d_in | input | 16 | Data bus, host-to-port direction |
| d_out | output | 16 | Data bus, port-to-host direction |
| d_oe | output | 1 | Data bus drive enable |
| ack_n | output | 1 | Acknowledge level, low when acknowledging |
| ack_oe | output | 1 | Acknowledge drive enable |
| irq | output | 1 | Interrupt level, active high |
| evt_set | input | 16 | Per-bit status event pulses |

## Verification
The bench goes after several corner cases.
- Strobe pulses with chip enable high: a port that does not gate on chip enable would acknowledge such a pulse or overwrite storage.
- Back-to-back strobes with chip enable held low: a design that detects only the chip-enable edge would drop the second transfer.
- An event that arrives in the middle of a held read: a design that reads the register file combinationally would let d_out change mid-cycle.
- A write-one-to-clear with a mixed mask: a design that clears the whole status word, or clears the zero bits, would leave irq at the wrong level.

// File: rtl/strobe_reg_port.sv
module strobe_reg_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              stb_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic              ack_n,
  output logic              ack_oe,
  output logic              irq,
  input  logic [DATA_W-1:0] evt_set
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0] ce_sy, stb_sy, rw_sy;
  logic       stb_prev;
  logic       start, wr_go;
  logic       ack_q, rd_act;
  logic [DATA_W-1:0] rdata_q, status_q, mask_q, w1c, rd_mux;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy    <= 2'b11;
      stb_sy   <= 2'b11;
      rw_sy    <= 2'b11;
      stb_prev <= 1'b1;
    end else begin
      ce_sy    <= {ce_sy[0], ce_n};
      stb_sy   <= {stb_sy[0], stb_n};
      rw_sy    <= {rw_sy[0], rd_wr};
      stb_prev <= stb_sy[1];
    end
  end

  assign start = stb_prev & ~stb_sy[1] & ~ce_sy[1];
  assign wr_go = start & ~rw_sy[1];
  assign w1c   = (wr_go && addr == '0) ? d_in : '0;

  always_comb begin
    case (addr)
      ADDR_W'(0): rd_mux = status_q;
      ADDR_W'(1): rd_mux = mask_q;
      default:    rd_mux = store[addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      status_q <= (status_q & ~w1c) | evt_set;
      if (wr_go && addr == ADDR_W'(1)) mask_q <= d_in;
      if (wr_go && addr > ADDR_W'(1)) store[addr] <= d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rd_act  <= 1'b0;
      rdata_q <= '0;
    end else if (stb_sy[1] || ce_sy[1]) begin
      ack_q  <= 1'b0;
      rd_act <= 1'b0;
    end else if (start) begin
      ack_q  <= 1'b1;
      rd_act <= rw_sy[1];
      if (rw_sy[1]) rdata_q <= rd_mux;
    end
  end

  assign d_out  = rdata_q;
  assign d_oe   = ~ce_n & ~stb_n & rd_wr & rd_act;
  assign ack_n  = ~ack_q;
  assign ack_oe = ~ce_n & ~stb_n & ack_q;
  assign irq    = |(status_q & mask_q);
endmodule

// File: rtl/strobe_reg_port_chk.sv
module strobe_reg_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              stb_n,
  input logic              rd_wr,
  input logic [DATA_W-1:0] d_out,
  input logic              d_oe,
  input logic              ack_n,
  input logic              ack_oe,
  input logic              irq,
  input logic [DATA_W-1:0] evt_set,
  input logic [DATA_W-1:0] mask_q
);
  a_r2_ce_gates_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!d_oe && !ack_oe));

  a_r4_bus_only_in_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (!stb_n && rd_wr && ack_oe));

  a_r5_no_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_n) && !ce_n) |-> !ack_oe);

  a_r5_ack_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    ack_oe |-> !ack_n);

  a_r9_read_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && $past(d_oe)) |-> $stable(d_out));

  a_r7_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & mask_q)) |=> (irq || !$stable(mask_q)));
endmodule

bind strobe_reg_port strobe_reg_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .stb_n(stb_n), .rd_wr(rd_wr),
  .d_out(d_out), .d_oe(d_oe), .ack_n(ack_n), .ack_oe(ack_oe), .irq(irq),
  .evt_set(evt_set), .mask_q(mask_q)
);

// File: tb/strobe_reg_port_bench.sv
module strobe_reg_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, stb_n = 1, rd_wr = 1;
  logic [4:0]  addr = '0;
  logic [15:0] d_in = '0, evt_set = '0;
  logic [15:0] d_out;
  logic d_oe, ack_n, ack_oe, irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mem_m [32];
  logic [15:0] status_m = '0, mask_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_reg_port u_strobe_reg_port (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .stb_n(stb_n), .rd_wr(rd_wr),
    .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .ack_n(ack_n),
    .ack_oe(ack_oe), .irq(irq), .evt_set(evt_set)
  );

  function automatic logic [15:0] model_rd(input logic [4:0] a);
    if (a == 0) return status_m;
    if (a == 1) return mask_m;
    return mem_m[a];
  endfunction

  function automatic logic model_irq();
    return |(status_m & mask_m);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit rd, input logic [4:0] a, input logic [15:0] wd,
                           input bit keep_ce, output logic [15:0] rv);
    @(negedge clk);
    ce_n = 0; rd_wr = rd; addr = a; d_in = wd;
    repeat (2) @(negedge clk);
    stb_n = 0;
    repeat (4) @(negedge clk);
    chk(ack_oe && !ack_n, "R5 ack present", {ack_oe, ack_n}, 2'b10);
    chk(d_oe == rd, "R4 bus drive matches direction", d_oe, rd);
    rv = d_out;
    stb_n = 1;
    #1;
    chk(!ack_oe && !d_oe, "R5 release on strobe rise", {ack_oe, d_oe}, 0);
    repeat (4) @(negedge clk);
    if (!keep_ce) ce_n = 1;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] wd, input bit keep_ce = 0);
    logic [15:0] dummy;
    bus_cycle(0, a, wd, keep_ce, dummy);
    if (a == 0) status_m &= ~wd;
    else if (a == 1) mask_m = wd;
    else mem_m[a] = wd;
  endtask

  task automatic bus_rd(input logic [4:0] a, input string tag, input bit keep_ce = 0);
    logic [15:0] rv;
    logic [15:0] exp;
    exp = model_rd(a);
    bus_cycle(1, a, 16'h0, keep_ce, rv);
    chk(rv === exp, tag, rv, exp);
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
    status_m |= v;
    chk(irq === model_irq(), "R7 irq level after event", irq, model_irq());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rv;
    logic [31:0] seed;
    for (int i = 0; i < 32; i++) mem_m[i] = '0;
    seed = $urandom(32'd20241);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!d_oe && !ack_oe && !irq, "R1 outputs idle after reset", {d_oe, ack_oe, irq}, 0);
    bus_rd(5'd0, "R1 status zero after reset");
    bus_rd(5'd1, "R1 mask zero after reset");
    bus_rd(5'd17, "R1 storage zero after reset");

    bus_wr(5'd2, 16'hA5C3);
    bus_wr(5'd31, 16'hFFFF);
    bus_rd(5'd2, "R3 readback low address");
    bus_rd(5'd31, "R3 readback top address");

    // R2: strobe with chip enable high
    @(negedge clk); ce_n = 1; rd_wr = 0; addr = 5'd2; d_in = 16'h1111;
    repeat (2) @(negedge clk); stb_n = 0;
    repeat (5) @(negedge clk);
    chk(!ack_oe && !d_oe, "R2 no drive with ce high", {ack_oe, d_oe}, 0);
    stb_n = 1; repeat (4) @(negedge clk);
    bus_rd(5'd2, "R2 write ignored with ce high");

    // R6: back-to-back with ce held low
    bus_wr(5'd7, 16'h0707, 1);
    bus_wr(5'd8, 16'h0808, 1);
    bus_rd(5'd7, "R6 back-to-back first", 1);
    bus_rd(5'd8, "R6 back-to-back second", 0);

    // R7 / R8 interrupt
    pulse_evt(16'h0005);
    chk(irq === 1'b0, "R7 masked status keeps irq low", irq, 0);
    bus_wr(5'd1, 16'h0004);
    @(negedge clk);
    chk(irq === 1'b1, "R7 unmasked status raises irq", irq, 1);
    bus_wr(5'd0, 16'h0004);
    @(negedge clk);
    chk(irq === 1'b0, "R8 w1c clears irq", irq, 0);
    bus_rd(5'd0, "R8 other status bit kept");

    // R9: event during held read
    bus_wr(5'd0, 16'hFFFF);
    @(negedge clk); ce_n = 0; rd_wr = 1; addr = 5'd0;
    repeat (2) @(negedge clk); stb_n = 0;
    repeat (4) @(negedge clk);
    rv = d_out;
    chk(rv === 16'h0000, "R9 captured status", rv, 16'h0000);
    evt_set = 16'h0100; @(negedge clk); evt_set = '0; status_m |= 16'h0100;
    repeat (2) @(negedge clk);
    chk(d_out === rv && d_oe, "R9 d_out held mid-cycle", d_out, rv);
    stb_n = 1; repeat (4) @(negedge clk); ce_n = 1;
    bus_rd(5'd0, "R9 new status visible next cycle");

    // random mix
    for (int n = 0; n < 80; n++) begin
      int op;
      logic [4:0] a;
      op = $urandom_range(0, 9);
      a = 5'($urandom_range(2, 31));
      if (op < 4) bus_wr(a, 16'($urandom));
      else if (op < 7) bus_rd(a, "R3 random readback");
      else if (op == 7) bus_wr(5'd1, 16'($urandom));
      else if (op == 8) pulse_evt(16'($urandom));
      else bus_wr(5'd0, 16'($urandom));
      @(negedge clk);
      chk(irq === model_irq(), "R7 random irq level", irq, model_irq());
    end
    bus_rd(5'd0, "R8 random final status");

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 0; #2;
    chk(!irq && !ack_oe && !d_oe, "R1 async reset clears outputs", {irq, ack_oe, d_oe}, 0);
    for (int i = 0; i < 32; i++) mem_m[i] = '0;
    status_m = '0; mask_m = '0;
    @(negedge clk); rst_n = 1;
    bus_rd(5'd2, "R1 storage cleared by reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule